// File: doc/BRIEF.md
# Serial EEPROM two-wire slave front end

This block is the bus-facing half of a 256-byte two-wire serial EEPROM. It sits on a system clock that runs much faster than the bus clock. Each bus line first passes through a synchroniser and a glitch filter. The block then tracks START and STOP conditions and answers only to the fixed 7-bit device address 1010000. It acts on byte writes, page writes, current-address reads, random reads and sequential reads. SDA is driven as an open-drain output: the block only ever asserts a drive-low enable.

Written bytes are not stored here. Each accepted data byte leaves as a one-cycle load strobe with its target address to a neighbouring page-buffer/commit block. A STOP that closes a write with at least one accepted byte sends a one-cycle commit strobe. While that neighbour reports busy, the block answers nothing, so a master can poll for completion. A write-protect input is strobed once per write session. Read data comes back combinationally from the memory at the block's current address output.

Top module: `i2c_eep_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) aborts any byte in progress and restarts bit counting for a fresh address byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The first byte after START is acknowledged only when its upper seven bits are 1010000. Bit 0 selects read (1) or write (0). Any other value, for example 0xA2 or 0xB0, is not acknowledged.
- R3: SDA is sampled on the rising edge of the filtered SCL. The drive-low output changes to a new asserted value only while the filtered SCL is low.
- R4: For every byte the master sends that the block accepts, SDA is held low throughout the 9th SCL clock. A refusal leaves SDA released during that clock.
- R5: In a write, the byte after the device address loads the address counter. Each later data byte produces one `load_o` pulse at {page bits, offset}, and the offset then increments modulo the 16-byte page. A STOP after at least one loaded byte produces exactly one `commit_o` pulse.
- R6: While `busy_i` is high, the block acknowledges no byte, including its own device address, and produces no load.
- R7: `wp_i` is sampled on the SCL falling edge that ends the acknowledge of the word-address byte. When it was high, the first data byte is not acknowledged and nothing is loaded or committed. A change of `wp_i` after that edge has no effect on the session.
- R8: In a read, the block shifts out the byte at `mem_addr_o`, most significant bit first, and then increments the address. A master ACK (SDA low on the 9th clock) continues with the next byte. A master NACK ends the read and releases SDA.
- R9: A write of a word address followed by a repeated START with a read address returns data starting at that word address.
- R10: During a sequential read the address wraps from 0xFF to 0x00.
- R11: A pulse on SCL or SDA shorter than FILT_CYCLES system clocks has no effect on the transfer.
- R12: After reset, SDA is released, `load_o` and `commit_o` are low and `mem_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low; otherwise SDA is released |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Internal write cycle in progress (from commit block) |
| mem_addr_o | output | ADDR_W | Current address counter, used as read address |
| mem_rdata_i | input | 8 | Memory byte at mem_addr_o |
| load_o | output | 1 | One-cycle strobe: load a byte into the page buffer |
| load_addr_o | output | ADDR_W | Target address of the loaded byte |
| load_data_o | output | 8 | Loaded byte |
| commit_o | output | 1 | One-cycle strobe: start the internal write cycle |

## Verification
The assertions assume that `busy_i` rises only after a commit strobe and stays quiet during a transfer the block has already acknowledged. They also assume that SDA changes while SCL is high only to form START or STOP. The bench's memory model raises busy only on `commit_o`. The bench master changes SDA 22 system clocks after each SCL fall, which is later than the filter and synchroniser delay, so the block's own SDA changes and the master's never cross. Glitches are injected only during the SCL low phase and are kept shorter than the filter length.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
   localparam int BYTE_W    = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_RDATA
   } eep_state_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CNT_W = $clog2(FILT_CYCLES + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_CYCLES <= 1) begin : g_nofilt
         assign dout = synced;
      end else begin : g_stable
         logic [CNT_W-1:0] cnt_q;
         logic             out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else if (synced == out_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
               out_q <= synced;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
         assign dout = out_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_eep_ctrl.sv
module i2c_eep_ctrl
   import i2c_eep_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1010000,
   parameter int         ADDR_W   = 8,
   parameter int         PAGE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_smp,
   input  logic              wp_i,
   input  logic              busy_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output logic              drive_low_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              load_o,
   output logic [ADDR_W-1:0] load_addr_o,
   output logic [BYTE_W-1:0] load_data_o,
   output logic              commit_o
);
   localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(8);
   localparam logic [BIT_CNT_W-1:0] ACK_END  = BIT_CNT_W'(9);

   eep_state_e           state;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic [BYTE_W-1:0]    sh, tx;
   logic [ADDR_W-1:0]    addr;
   logic                 rw, mack, wp_lat, wr_pend;

   function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] r;
      r = a;
      r[PAGE_W-1:0] = a[PAGE_W-1:0] + PAGE_W'(1);
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bit_cnt     <= '0;
         sh          <= '0;
         tx          <= '0;
         addr        <= '0;
         rw          <= 1'b0;
         mack        <= 1'b0;
         wp_lat      <= 1'b0;
         wr_pend     <= 1'b0;
         drive_low_o <= 1'b0;
         load_o      <= 1'b0;
         load_addr_o <= '0;
         load_data_o <= '0;
         commit_o    <= 1'b0;
      end else begin
         load_o   <= 1'b0;
         commit_o <= 1'b0;
         if (start_ev) begin
            state       <= ST_DEV;
            bit_cnt     <= '0;
            drive_low_o <= 1'b0;
            wr_pend     <= 1'b0;
         end else if (stop_ev) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            drive_low_o <= 1'b0;
            commit_o    <= wr_pend;
            wr_pend     <= 1'b0;
         end else if (state != ST_IDLE) begin
            if (scl_rise) begin
               if (bit_cnt < ACK_SLOT) sh <= {sh[BYTE_W-2:0], sda_smp};
               if (bit_cnt == ACK_SLOT) mack <= ~sda_smp;
               if (bit_cnt < ACK_END) bit_cnt <= bit_cnt + BIT_CNT_W'(1);
            end else if (scl_fall) begin
               if (bit_cnt == ACK_SLOT) begin
                  case (state)
                     ST_DEV: begin
                        if (sh[7:1] == DEV_ADDR && !busy_i) begin
                           drive_low_o <= 1'b1;
                           rw          <= sh[0];
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     ST_WADDR: begin
                        addr        <= sh[ADDR_W-1:0];
                        drive_low_o <= 1'b1;
                     end
                     ST_WDATA: begin
                        if (wp_lat) begin
                           state <= ST_IDLE;
                        end else begin
                           drive_low_o <= 1'b1;
                           load_o      <= 1'b1;
                           load_addr_o <= addr;
                           load_data_o <= sh;
                           addr        <= page_next(addr);
                           wr_pend     <= 1'b1;
                        end
                     end
                     default: drive_low_o <= 1'b0;
                  endcase
               end else if (bit_cnt == ACK_END) begin
                  bit_cnt     <= '0;
                  drive_low_o <= 1'b0;
                  case (state)
                     ST_DEV: begin
                        if (rw) begin
                           state       <= ST_RDATA;
                           tx          <= rdata_i;
                           drive_low_o <= ~rdata_i[BYTE_W-1];
                           addr        <= addr + ADDR_W'(1);
                        end else begin
                           state <= ST_WADDR;
                        end
                     end
                     ST_WADDR: begin
                        state  <= ST_WDATA;
                        wp_lat <= wp_i;
                     end
                     ST_RDATA: begin
                        if (mack) begin
                           tx          <= rdata_i;
                           drive_low_o <= ~rdata_i[BYTE_W-1];
                           addr        <= addr + ADDR_W'(1);
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     default: ;
                  endcase
               end else if (state == ST_RDATA && bit_cnt != '0) begin
                  drive_low_o <= ~tx[3'd7 - bit_cnt[2:0]];
               end
            end
         end
      end
   end

   assign addr_o = addr;
endmodule

// File: rtl/i2c_eep_slave.sv
module i2c_eep_slave
   import i2c_eep_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 12,
   parameter logic [6:0] DEV_ADDR    = 7'b1010000,
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low_o,
   input  logic              wp_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [7:0]        mem_rdata_i,
   output logic              load_o,
   output logic [ADDR_W-1:0] load_addr_o,
   output logic [7:0]        load_data_o,
   output logic              commit_o
);
   localparam int LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..8");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must lie in 1..ADDR_W-1");
      end
   endgenerate

   logic [LINES-1:0] raw, filt;
   logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

   assign raw = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
         );
      end
   endgenerate

   assign scl_f = filt[0];
   assign sda_f = filt[1];

   i2c_cond_detect u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (scl_f),
      .sda_f   (sda_f),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev)
   );

   i2c_eep_ctrl #(
      .DEV_ADDR(DEV_ADDR),
      .ADDR_W  (ADDR_W),
      .PAGE_W  (PAGE_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_ev   (start_ev),
      .stop_ev    (stop_ev),
      .sda_smp    (sda_f),
      .wp_i       (wp_i),
      .busy_i     (busy_i),
      .rdata_i    (mem_rdata_i),
      .drive_low_o(sda_drive_low_o),
      .addr_o     (mem_addr_o),
      .load_o     (load_o),
      .load_addr_o(load_addr_o),
      .load_data_o(load_data_o),
      .commit_o   (commit_o)
   );
endmodule

// File: rtl/i2c_eep_slave_chk.sv
module i2c_eep_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_f,
   input logic stop_ev,
   input logic sda_drive_low_o,
   input logic busy_i,
   input logic load_o,
   input logic commit_o
);
   // R1: a STOP leaves SDA released on the next cycle
   assert_release_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_drive_low_o);

   // R3: a new drive-low begins only while the filtered clock is low
   assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low_o) |-> !scl_f);

   // R6: no load and no acknowledge while the write cycle runs
   assert_no_load_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> !load_o);

   assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> !$rose(sda_drive_low_o));

   // R5: strobes last one cycle and never coincide
   assert_load_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);

   assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o);

   assert_commit_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> !load_o);
endmodule

bind i2c_eep_slave i2c_eep_slave_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .scl_f          (scl_f),
   .stop_ev        (stop_ev),
   .sda_drive_low_o(sda_drive_low_o),
   .busy_i         (busy_i),
   .load_o         (load_o),
   .commit_o       (commit_o)
);

// File: tb/tb_i2c_eep_slave.sv
`timescale 1ns/1ps
module tb_i2c_eep_slave;
   localparam int BUSY_CYC = 3000;
   localparam int NVEC     = 4;
   // fields: start address [20:13], byte count [12:8], data seed [7:0]
   localparam logic [20:0] VEC [NVEC] = '{
      {8'h10, 5'd1,  8'h11},
      {8'h35, 5'd4,  8'h40},
      {8'h7C, 5'd8,  8'h90},
      {8'hF8, 5'd20, 8'h03}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic drv, load, commit, busy;
   logic [7:0] maddr, rdata, laddr, ldata;
   wire bus = sda_m & ~drv;

   always #4 clk = ~clk;

   logic [7:0] mem [256];
   logic [7:0] pbuf [256];
   logic       pv [256];
   logic [7:0] ex [256];
   int busy_cnt, n_commit, n_load;
   int n_chk = 0, n_bad = 0;

   assign busy  = (busy_cnt != 0);
   assign rdata = mem[maddr];

   i2c_eep_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus),
      .sda_drive_low_o(drv), .wp_i(wp), .busy_i(busy),
      .mem_addr_o(maddr), .mem_rdata_i(rdata),
      .load_o(load), .load_addr_o(laddr), .load_data_o(ldata),
      .commit_o(commit)
   );

   // page buffer and memory model driven only through the ports
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) begin
            mem[i] <= 8'hFF;
            pv[i]  <= 1'b0;
         end
         busy_cnt <= 0; n_commit <= 0; n_load <= 0;
      end else begin
         if (load) begin
            pbuf[laddr] <= ldata;
            pv[laddr]   <= 1'b1;
            n_load      <= n_load + 1;
         end
         if (commit) begin
            for (int i = 0; i < 256; i++) begin
               if (pv[i]) mem[i] <= pbuf[i];
               pv[i] <= 1'b0;
            end
            busy_cnt <= BUSY_CYC;
            n_commit <= n_commit + 1;
         end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, input logic glitch, output logic s);
      wait_clk(22);
      sda_m = b;
      if (glitch) begin
         wait_clk(3);
         scl_m = 1'b1;
         wait_clk(5);
         scl_m = 1'b0;
         wait_clk(4);
      end else begin
         wait_clk(12);
      end
      scl_m = 1'b1;
      wait_clk(15);
      s = bus;
      wait_clk(15);
      scl_m = 1'b0;
   endtask

   task automatic i2c_start();
      wait_clk(22);
      sda_m = 1'b1;
      wait_clk(12);
      scl_m = 1'b1;
      wait_clk(20);
      sda_m = 1'b0;
      wait_clk(20);
      scl_m = 1'b0;
   endtask

   task automatic i2c_stop();
      wait_clk(22);
      sda_m = 1'b0;
      wait_clk(12);
      scl_m = 1'b1;
      wait_clk(20);
      sda_m = 1'b1;
      wait_clk(30);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch, s);
      clk_bit(1'b1, 1'b0, s);
      ack = ~s;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, 1'b0, s);
         b[i] = s;
      end
      clk_bit(~give_ack, 1'b0, s);
   endtask

   task automatic poll_ready(output int nacks);
      logic a;
      nacks = 0;
      for (int k = 0; k < 40; k++) begin
         i2c_start();
         send_byte(8'hA0, 1'b0, a);
         i2c_stop();
         if (a) break;
         nacks++;
      end
   endtask

   task automatic read_seq(input logic [7:0] a, input int n, input string tag);
      logic ack;
      logic [7:0] b;
      i2c_start();
      send_byte(8'hA0, 1'b0, ack);
      send_byte(a, 1'b0, ack);
      i2c_start();
      send_byte(8'hA1, 1'b0, ack);
      check({tag, " read address ack"}, int'(ack), 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, b);
         check($sformatf("%s R3 R8 byte at %02h", tag, 8'(a + 8'(i))), int'(b), int'(ex[8'(a + 8'(i))]));
      end
      i2c_stop();
   endtask

   task automatic write_page(input logic [7:0] a, input int n, input logic [7:0] seed);
      logic ack;
      int okacks, c0, l0, nk;
      logic [7:0] d;
      c0 = n_commit;
      l0 = n_load;
      okacks = 0;
      i2c_start();
      send_byte(8'hA0, 1'b0, ack); okacks += int'(ack);
      send_byte(a, 1'b0, ack);     okacks += int'(ack);
      for (int i = 0; i < n; i++) begin
         d = seed + 8'(i * 37);
         send_byte(d, 1'b0, ack);
         okacks += int'(ack);
         ex[{a[7:4], a[3:0] + 4'(i)}] = d;
      end
      i2c_stop();
      wait_clk(4);
      check("R4 acks on every written byte", okacks, n + 2);
      check("R5 load count", n_load - l0, n);
      check("R5 one commit at STOP", n_commit - c0, 1);
      poll_ready(nk);
      check("R6 NACK while busy", int'(nk > 0), 1);
   endtask

   initial begin
      logic ack;
      logic [7:0] b;
      int c0, l0, nk;
      for (int i = 0; i < 256; i++) ex[i] = 8'hFF;
      wait_clk(5);
      check("R12 reset drive", int'(drv), 0);
      check("R12 reset load", int'(load), 0);
      check("R12 reset commit", int'(commit), 0);
      check("R12 reset address", int'(maddr), 0);
      rst_n = 1'b1;
      wait_clk(20);

      // table walk: page writes then read back whole page (R5 R9)
      for (int v = 0; v < NVEC; v++) begin
         write_page(VEC[v][20:13], int'(VEC[v][12:8]), VEC[v][7:0]);
         read_seq({VEC[v][20:17], 4'h0}, 16, "R5 R9 page");
      end

      // R2: foreign addresses
      i2c_start(); send_byte(8'hA2, 1'b0, ack); i2c_stop();
      check("R2 address A2 refused", int'(ack), 0);
      i2c_start(); send_byte(8'hB0, 1'b0, ack); i2c_stop();
      check("R2 address B0 refused", int'(ack), 0);

      // R1: START in the middle of a byte restarts addressing
      i2c_start();
      clk_bit(1'b1, 1'b0, ack); clk_bit(1'b0, 1'b0, ack);
      clk_bit(1'b1, 1'b0, ack); clk_bit(1'b0, 1'b0, ack);
      i2c_start();
      send_byte(8'hA0, 1'b0, ack);
      i2c_stop();
      check("R1 ack after restarted byte", int'(ack), 1);
      check("R1 STOP releases SDA", int'(drv), 0);

      // R7: protected write refused
      c0 = n_commit; l0 = n_load;
      wp = 1'b1;
      i2c_start();
      send_byte(8'hA0, 1'b0, ack);
      send_byte(8'h20, 1'b0, ack);
      send_byte(8'h5A, 1'b0, ack);
      i2c_stop();
      wp = 1'b0;
      wait_clk(4);
      check("R7 protected data NACK", int'(ack), 0);
      check("R7 no load when protected", n_load - l0, 0);
      check("R7 no commit when protected", n_commit - c0, 0);
      read_seq(8'h20, 1, "R7 protected byte unchanged");

      // R7: protect raised after the strobe edge is ignored
      i2c_start();
      send_byte(8'hA0, 1'b0, ack);
      send_byte(8'h21, 1'b0, ack);
      wait_clk(25);
      wp = 1'b1;
      send_byte(8'h66, 1'b0, ack);
      i2c_stop();
      wp = 1'b0;
      check("R7 late protect ignored", int'(ack), 1);
      ex[8'h21] = 8'h66;
      poll_ready(nk);
      read_seq(8'h21, 1, "R7 late protect data");

      // R10: sequential wrap, then R8 current address read
      read_seq(8'hFE, 4, "R10 wrap");
      i2c_start();
      send_byte(8'hA1, 1'b0, ack);
      read_byte(1'b0, b);
      i2c_stop();
      check("R8 current address ack", int'(ack), 1);
      check("R8 current address data", int'(b), int'(ex[8'h02]));
      check("R8 released after NACK", int'(drv), 0);

      // R11: short SCL glitches inside every bit
      i2c_start();
      send_byte(8'hA0, 1'b1, ack);
      check("R11 glitched address ack", int'(ack), 1);
      send_byte(8'h30, 1'b1, ack);
      send_byte(8'h77, 1'b1, ack);
      i2c_stop();
      check("R11 glitched data ack", int'(ack), 1);
      ex[8'h30] = 8'h77;
      poll_ready(nk);
      read_seq(8'h30, 1, "R11 glitched write");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule